// File: doc/BRIEF.md
# Bus Clock and Chip-Select Generator

This block turns a free-running master clock into a slower bus clock and uses that bus clock to qualify a coarse memory-map decode. One bus-clock period spans twelve master cycles. The bus clock stays low for four and a half master cycles and high for seven and a half, which is a 5/8 duty cycle. The half-cycle boundary can only be placed by using both edges of the master clock. The three upper address bits are decoded into three active-low selects: program ROM, a peripheral data-bus enable and work RAM. Each select can only be asserted while the bus clock is high.

The decode is built from two chained 2-to-4 demultiplexers with active-low outputs. The first is always enabled. It combines the bus clock with the top address bit, and one of its outputs drives the ROM select directly. A second output of the first demultiplexer enables the second one, which decodes the next two address bits into the peripheral and RAM selects. Address codes 010 and 011 select nothing.

Top module: `busclk_cs_gen`

## Requirements
- R1: The bus clock `m2_o` is periodic with a period of exactly 12 master-clock cycles (24 half cycles).
- R2: Within each period `m2_o` is low for 9 half cycles (4.5 master cycles) and high for 15 half cycles (7.5 master cycles).
- R3: While `rst_n` is sampled low at a rising master edge, `m2_o` is low from that edge onward and all selects are high. After release, the 4th rising master edge is the first one that drives `m2_o` high.
- R4: `rom_sel_n` is low exactly when `m2_o` is high and `addr_hi[2]` (address bit 15) is 1.
- R5: `pbus_en_n` is low exactly when `m2_o` is high and `addr_hi` (bits 15..13) equals 3'b001.
- R6: `ram_sel_n` is low exactly when `m2_o` is high and `addr_hi` equals 3'b000.
- R7: For `addr_hi` equal to 3'b010 or 3'b011, all three selects stay high in every phase of the bus clock.
- R8: While `m2_o` is low, all three selects are high, whatever the address.
- R9: At most one select is low at any time.
- R10: `m2_o` rises only at a rising master-clock edge and falls only at a falling master-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the rising master edge |
| addr_hi | input | 3 | Address bits 15..13 (bit 2 = A15) |
| m2_o | output | 1 | Bus clock, 12 master cycles per period, 5/8 high |
| rom_sel_n | output | 1 | Active-low ROM select |
| pbus_en_n | output | 1 | Active-low peripheral data-bus enable |
| ram_sel_n | output | 1 | Active-low RAM select |

## Verification
The hardest behaviour to reach from the ports is the half-cycle placement of the bus-clock edges. Sampling only at one clock edge would hide whether the fall really lands on the falling master edge. The bench therefore samples every half cycle, shortly after each master edge. It steps the address at each half so that, over several periods, all eight codes meet every one of the 24 phase slots. A second reset is applied while the bus clock is high. This checks that the bus clock is forced low at once and that the phase restarts from the beginning.

// File: rtl/busclk_pkg.sv
`timescale 1ns/1ps
// Package: busclk_pkg
// Shared constants for the bus clock and chip-select generator.
// Assumes: one bus period = 12 master cycles, low time = RISE_PH + 0.5 cycles.
package busclk_pkg;
    // Default number of master cycles per bus-clock period
    localparam int unsigned BUS_PERIOD_DEF = 12;
    // Default phase at which the bus clock goes high (rising master edge)
    localparam int unsigned BUS_RISE_DEF   = 4;
    // Output index of a 2-to-4 demultiplexer for a given {a1,a0} code
    localparam int unsigned DMX_CODE_00 = 0;
    localparam int unsigned DMX_CODE_01 = 1;
    localparam int unsigned DMX_CODE_10 = 2;
    localparam int unsigned DMX_CODE_11 = 3;
endpackage

// File: rtl/m2_phase_gen.sv
`timescale 1ns/1ps
// Module: m2_phase_gen
// Produces the bus clock from the master clock at half-cycle resolution.
// A phase counter on the rising edge marks the high window, which starts at
// phase RISE_PH. A register on the falling edge ends the window half a cycle
// before phase 0. The two registered terms are ANDed. They change on opposite
// master edges, so the AND never sees two inputs moving at once.
// Assumes: 1 <= RISE_PH <= PERIOD-2, synchronous active-low reset.
module m2_phase_gen #(
    parameter int unsigned PERIOD  = 12,
    parameter int unsigned RISE_PH = 4
) (
    input  logic clk_mst,
    input  logic rst_n,
    output logic m2
);
    localparam int unsigned PH_W    = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(RISE_PH);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_nxt;
    logic            win_pos_q;   // high window, rising-edge term
    logic            keep_neg_q;  // clears on the falling edge of the last phase

    // Next phase: wrap at the end of the period
    always_comb begin
        phase_nxt = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    // Phase counter and rising-edge window term
    always_ff @(posedge clk_mst) begin
        if (!rst_n) begin
            phase_q   <= '0;
            win_pos_q <= 1'b0;
        end else begin
            phase_q   <= phase_nxt;
            win_pos_q <= (phase_nxt >= PH_RISE);
        end
    end

    // Falling-edge term: drops half a cycle into the last phase
    always_ff @(negedge clk_mst) begin
        if (!rst_n) begin
            keep_neg_q <= 1'b0;
        end else begin
            keep_neg_q <= (phase_q != PH_LAST);
        end
    end

    // Combine the two edge-generated terms
    assign m2 = win_pos_q & keep_neg_q;
endmodule

// File: rtl/dmx24_n.sv
`timescale 1ns/1ps
// Module: dmx24_n
// 2-to-4 demultiplexer with active-low enable and active-low outputs.
// When disabled, all outputs are high. When enabled, only the output indexed
// by {a1,a0} is low.
// Assumes: purely combinational, no timing of its own.
module dmx24_n (
    input  logic       en_n,
    input  logic       a0,
    input  logic       a1,
    output logic [3:0] y_n
);
    logic [1:0] code;

    // Form the select code
    assign code = {a1, a0};

    // One output per code, built by generate
    for (genvar gi = 0; gi < 4; gi++) begin : g_out
        assign y_n[gi] = ~(~en_n & (code == 2'(gi)));
    end
endmodule

// File: rtl/busclk_cs_gen.sv
`timescale 1ns/1ps
// Module: busclk_cs_gen (top)
// Bus clock generator plus an address decode gated by the bus clock.
// First demultiplexer: always enabled, inputs {A15, M2}. Its output for code
//   11 is the ROM select, and its output for code 01 (M2 high, A15 low)
//   enables the second demultiplexer.
// Second demultiplexer: inputs {A14, A13}. Code 00 is the RAM select and
//   code 01 is the peripheral enable.
// Assumes: addr_hi is settled while the selects are used.
module busclk_cs_gen
    import busclk_pkg::*;
#(
    parameter int unsigned PERIOD  = BUS_PERIOD_DEF,
    parameter int unsigned RISE_PH = BUS_RISE_DEF
) (
    input  logic       clk_mst,
    input  logic       rst_n,
    input  logic [2:0] addr_hi,
    output logic       m2_o,
    output logic       rom_sel_n,
    output logic       pbus_en_n,
    output logic       ram_sel_n
);
    logic       m2;
    logic [3:0] upper_y_n;
    logic [3:0] lower_y_n;

    // Bus clock
    m2_phase_gen #(
        .PERIOD (PERIOD),
        .RISE_PH(RISE_PH)
    ) u_phase (
        .clk_mst(clk_mst),
        .rst_n  (rst_n),
        .m2     (m2)
    );

    // Upper decode: A15 together with the bus clock
    dmx24_n u_dmx_upper (
        .en_n(1'b0),
        .a0  (m2),
        .a1  (addr_hi[2]),
        .y_n (upper_y_n)
    );

    // Lower decode: A14/A13, enabled by "M2 high and A15 low"
    dmx24_n u_dmx_lower (
        .en_n(upper_y_n[DMX_CODE_01]),
        .a0  (addr_hi[0]),
        .a1  (addr_hi[1]),
        .y_n (lower_y_n)
    );

    // Drive the outputs
    assign m2_o      = m2;
    assign rom_sel_n = upper_y_n[DMX_CODE_11];
    assign pbus_en_n = lower_y_n[DMX_CODE_01];
    assign ram_sel_n = lower_y_n[DMX_CODE_00];
endmodule

// File: rtl/busclk_cs_chk.sv
`timescale 1ns/1ps
// Module: busclk_cs_chk
// Property checker for busclk_cs_gen, attached by bind.
// Assumes: the same PERIOD as the design instance.
module busclk_cs_chk #(
    parameter int unsigned PERIOD = 12
) (
    input logic       clk_mst,
    input logic       rst_n,
    input logic [2:0] addr_hi,
    input logic       m2_o,
    input logic       rom_sel_n,
    input logic       pbus_en_n,
    input logic       ram_sel_n
);
    localparam int unsigned CW = $clog2(PERIOD) + 2;

    logic          m2_d;
    logic          seen_rise;
    logic [CW-1:0] since_rise;

    // Track bus-clock rises and the rising edges counted since the last one
    always_ff @(posedge clk_mst) begin
        if (!rst_n) begin
            m2_d       <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
        end else begin
            m2_d <= m2_o;
            if (m2_o && !m2_d) begin
                seen_rise  <= 1'b1;
                since_rise <= '0;
            end else if (since_rise != '1) begin
                since_rise <= since_rise + 1'b1;
            end
        end
    end

    // R1: consecutive rises are PERIOD rising edges apart
    a_r1_period: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (m2_o && !m2_d && seen_rise) |-> (since_rise == CW'(PERIOD - 1)));

    // R3: reset forces the bus clock low
    a_r3_reset_low: assert property (@(posedge clk_mst)
        !rst_n |=> !m2_o);

    // R4: ROM select only with the bus clock high and A15 set
    a_r4_rom: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !rom_sel_n |-> (m2_o && addr_hi[2]));

    // R5: peripheral enable only for code 001 with the bus clock high
    a_r5_pbus: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !pbus_en_n |-> (m2_o && addr_hi == 3'b001));

    // R6: RAM select only for code 000 with the bus clock high
    a_r6_ram: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !ram_sel_n |-> (m2_o && addr_hi == 3'b000));

    // R7: unused codes select nothing
    a_r7_gap: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (addr_hi[2:1] == 2'b01) |-> (rom_sel_n && pbus_en_n && ram_sel_n));

    // R8: no select while the bus clock is low
    a_r8_m2_low: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !m2_o |-> (rom_sel_n && pbus_en_n && ram_sel_n));

    // R9: at most one select active
    a_r9_exclusive: assert property (@(posedge clk_mst) disable iff (!rst_n)
        $onehot0({~rom_sel_n, ~pbus_en_n, ~ram_sel_n}));
endmodule

bind busclk_cs_gen busclk_cs_chk #(.PERIOD(PERIOD)) u_chk (
    .clk_mst  (clk_mst),
    .rst_n    (rst_n),
    .addr_hi  (addr_hi),
    .m2_o     (m2_o),
    .rom_sel_n(rom_sel_n),
    .pbus_en_n(pbus_en_n),
    .ram_sel_n(ram_sel_n)
);

// File: tb/busclk_cs_gen_tb.sv
`timescale 1ns/1ps
// Bench: samples every half cycle and steps the address each half
module busclk_cs_gen_tb;
    localparam int PERIOD  = 12;
    localparam int RISE_PH = 4;

    logic       clk_mst = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] addr_hi = 3'b000;
    logic       m2_o, rom_sel_n, pbus_en_n, ram_sel_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench-side model state
    int ph;           // phase of the current master cycle
    int run_len;      // halves at the current m2 level
    int run_valid;    // 1 once the first edge of m2 has been seen
    int last_rise;    // half index of the previous rise
    int half_idx;
    logic prev_m2;

    busclk_cs_gen #(.PERIOD(PERIOD), .RISE_PH(RISE_PH)) u_dut (
        .clk_mst  (clk_mst),
        .rst_n    (rst_n),
        .addr_hi  (addr_hi),
        .m2_o     (m2_o),
        .rom_sel_n(rom_sel_n),
        .pbus_en_n(pbus_en_n),
        .ram_sel_n(ram_sel_n)
    );

    always #2.5 clk_mst = ~clk_mst;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Checks one half-cycle sample against the arithmetic model
    task automatic sample(input bit second_half, input int addr_sel);
        logic exp_m2;
        logic [2:0] a;
        a = 3'(addr_sel);
        addr_hi = a;
        #0.5;
        exp_m2 = (ph >= RISE_PH) && !(second_half && ph == PERIOD - 1);
        chk("R2 m2 level", {31'd0, m2_o}, {31'd0, exp_m2});
        chk("R4 rom", {31'd0, rom_sel_n}, {31'd0, ~(exp_m2 & a[2])});
        chk("R5 pbus", {31'd0, pbus_en_n}, {31'd0, ~(exp_m2 & (a == 3'b001))});
        chk("R6 ram", {31'd0, ram_sel_n}, {31'd0, ~(exp_m2 & (a == 3'b000))});
        if (a[2:1] == 2'b01)
            chk("R7 gap code", {29'd0, rom_sel_n, pbus_en_n, ram_sel_n}, 32'h7);
        if (!m2_o)
            chk("R8 m2 low", {29'd0, rom_sel_n, pbus_en_n, ram_sel_n}, 32'h7);
        chk("R9 exclusive", {31'd0, ({rom_sel_n, pbus_en_n, ram_sel_n} inside
            {3'b111, 3'b011, 3'b101, 3'b110})}, 32'd1);
        // edge placement and run lengths
        if (m2_o !== prev_m2) begin
            if (m2_o) begin
                chk("R10 rise on rising edge", {31'd0, second_half}, 32'd0);
                if (run_valid) begin
                    chk("R2 low halves", run_len, 9);
                    if (last_rise >= 0)
                        chk("R1 period halves", half_idx - last_rise, 2 * PERIOD);
                end
                last_rise = half_idx;
            end else begin
                chk("R10 fall on falling edge", {31'd0, second_half}, 32'd1);
                if (run_valid)
                    chk("R2 high halves", run_len, 15);
            end
            run_valid = 1;
            run_len   = 1;
        end else begin
            run_len++;
        end
        prev_m2 = m2_o;
        half_idx++;
    endtask

    // Runs whole periods from a fresh release of reset
    task automatic run_periods(input int n);
        ph = 0; run_len = 0; run_valid = 0; last_rise = -1; half_idx = 0;
        prev_m2 = 1'b0;
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < PERIOD; c++) begin
                @(posedge clk_mst);
                ph = (ph + 1) % PERIOD;
                #0.5;
                sample(1'b0, (half_idx + p) % 8);
                @(negedge clk_mst);
                #0.5;
                sample(1'b1, (half_idx + p) % 8);
            end
        end
    endtask

    initial begin
        repeat (4) @(posedge clk_mst);
        #1;
        chk("R3 reset m2", {31'd0, m2_o}, 32'd0);
        chk("R3 reset selects", {29'd0, rom_sel_n, pbus_en_n, ram_sel_n}, 32'h7);
        @(negedge clk_mst);
        rst_n = 1'b1;
        run_periods(10);
        // reset in the middle of the high window
        while (!(ph >= 6 && ph <= 8)) begin
            @(posedge clk_mst);
            ph = (ph + 1) % PERIOD;
        end
        @(negedge clk_mst);
        chk("R3 pre-reset m2 high", {31'd0, m2_o}, 32'd1);
        addr_hi = 3'b000;
        rst_n = 1'b0;
        @(posedge clk_mst);
        #1;
        chk("R3 m2 forced low", {31'd0, m2_o}, 32'd0);
        chk("R3 ram released", {31'd0, ram_sel_n}, 32'd1);
        @(negedge clk_mst);
        rst_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk_mst);
            #1;
            chk("R3 restart rise", {31'd0, m2_o}, {31'd0, (k == 4)});
        end
        @(negedge clk_mst);
        rst_n = 1'b0;
        @(posedge clk_mst);
        @(negedge clk_mst);
        rst_n = 1'b1;
        run_periods(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule